// File: doc/BRIEF.md
# Watch Timer with Buzzer Output

This block produces the slow real-time tick of a chip. A base rate of nominally 32.768 kHz is formed either from a main-clock enable strobe divided by 128 or directly from a subsystem-clock enable strobe. A mode bit picks which one is used. The base rate drives a 14-stage divider. Each time the divider wraps, the block raises a sticky flag and gives a one-cycle pulse that can wake the system from standby. The wrap comes every 16384 base ticks (0.5 s) in normal mode, and every 128 base ticks (about 3.91 ms) in a fast mode meant for debug and test.

Stage 3 of the same divider gives a square wave at one sixteenth of the base rate (2.048 kHz). This wave can be routed to a buzzer pin, subject to the port output latch and the port output-mode bit. Software can hold the divider at zero through a mode bit, so that timekeeping starts from zero seconds. Software clears the flag with a read-test strobe.

All logic runs on one clock. The two rate inputs are single-cycle enable strobes, not clocks.

Top module: `rtc_watch_timer`

## Requirements
- R1: After reset, flag_o, wake_o and buz_pin_o are 0, and the divider and the main prescaler are at zero.
- R2: The source select is mode_i bit 0. When it is 0, one base tick occurs on every 128th main_tick_i strobe. When it is 1, every sub_tick_i strobe is a base tick.
- R3: When mode_i bit 1 is 0 (normal mode), a divider wrap occurs on every 16384th base tick, counted from a cleared divider.
- R4: When mode_i bit 1 is 1 (fast mode), a wrap occurs on every 128th base tick, counted from a cleared divider.
- R5: A wrap on a clock edge sets flag_o and wake_o in the following cycle. wake_o stays high for that one cycle only.
- R6: flag_o stays set until a cycle with test_i high clears it. If a wrap occurs in the same cycle as test_i, flag_o stays set.
- R7: When mode_i bit 2 (count enable) is 0, the divider and the prescaler keep their values and no wrap occurs. Counting resumes from the held values.
- R8: While mode_i bit 4 (clear) is 1, the divider and the prescaler are held at zero and no wrap occurs. After release, a full interval elapses before the next wrap.
- R9: The buzzer wave is divider stage 3. After k base ticks from a cleared divider, the wave is high when (k mod 16) is 8 to 15.
- R10: buz_pin_o is 0 when port_out_i is 0. When port_out_i is 1 and mode_i bit 3 (buzzer enable) is 0, buz_pin_o equals port_latch_i. When port_out_i is 1 and bit 3 is 1, buz_pin_o is the buzzer wave while port_latch_i is 0, and 0 while port_latch_i is 1.
- R11: mode_i bits 7 to 5 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| main_tick_i | input | 1 | Main-clock rate enable strobe |
| sub_tick_i | input | 1 | Subsystem-clock rate enable strobe |
| mode_i | input | 8 | Mode: bit0 source, bit1 fast, bit2 count enable, bit3 buzzer enable, bit4 clear |
| test_i | input | 1 | Read-test strobe that clears the flag |
| port_latch_i | input | 1 | Port output latch value |
| port_out_i | input | 1 | Port output-mode bit |
| flag_o | output | 1 | Sticky tick flag |
| wake_o | output | 1 | One-cycle standby-wake pulse |
| buz_pin_o | output | 1 | Buzzer pin drive |

## Verification
The assertions assume that rate strobes are at most one per clock. They also assume that at least 128 base ticks pass between wraps, which the divider itself guarantees. From these, wake pulses can never be adjacent. The stimulus never drives the strobes for more than one cycle per tick. It changes mode_i only between edges and applies clear for at least one full cycle before each interval measurement. In the random phase, clear and test are drawn rarely and the reserved mode bits are drawn freely.

// File: rtl/rtc_watch_pkg.sv
package rtc_watch_pkg;
  typedef struct packed {
    logic [2:0] rsvd;
    logic       clr;
    logic       buz_en;
    logic       cnt_en;
    logic       fast;
    logic       src_sub;
  } wt_mode_t;
endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
  parameter int unsigned DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i & ~clr_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && tick_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wt_divider.sv
module wt_divider #(
  parameter int unsigned W      = 14,
  parameter int unsigned FAST_W = 7,
  parameter int unsigned TAP    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic step_i,
  input  logic fast_i,
  output logic wrap_o,
  output logic tap_o
);
  logic [W-1:0] cnt_q;
  logic         full_wrap, fast_wrap, adv;

  assign adv       = run_i & ~clr_i & step_i;
  assign full_wrap = &cnt_q;
  assign fast_wrap = &cnt_q[FAST_W-1:0];
  assign wrap_o    = adv & (fast_i ? fast_wrap : full_wrap);
  assign tap_o     = cnt_q[TAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wt_pin_mux.sv
module wt_pin_mux (
  input  logic buz_en_i,
  input  logic wave_i,
  input  logic latch_i,
  input  logic out_i,
  output logic pin_o
);
  logic drive;
  // buzzer passes only while the latch is parked low
  assign drive = buz_en_i ? (wave_i & ~latch_i) : latch_i;
  assign pin_o = out_i & drive;
endmodule

// File: rtl/rtc_watch_timer.sv
module rtc_watch_timer
  import rtc_watch_pkg::*;
#(
  parameter int unsigned PRE_DIV = 128,
  parameter int unsigned DIV_W   = 14,
  parameter int unsigned FAST_W  = 7,
  parameter int unsigned BUZ_TAP = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_tick_i,
  input  logic       sub_tick_i,
  input  logic [7:0] mode_i,
  input  logic       test_i,
  input  logic       port_latch_i,
  input  logic       port_out_i,
  output logic       flag_o,
  output logic       wake_o,
  output logic       buz_pin_o
);
  wt_mode_t mode;
  logic     pre_tick, base_tick, wrap, wave;
  logic     flag_q, wake_q;

  assign mode = wt_mode_t'(mode_i);

  wt_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .run_i (mode.cnt_en), .clr_i(mode.clr),
    .tick_i(main_tick_i), .tick_o(pre_tick)
  );

  assign base_tick = mode.src_sub ? sub_tick_i : pre_tick;

  wt_divider #(.W(DIV_W), .FAST_W(FAST_W), .TAP(BUZ_TAP)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .run_i (mode.cnt_en), .clr_i(mode.clr),
    .step_i(base_tick), .fast_i(mode.fast),
    .wrap_o(wrap), .tap_o(wave)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= wrap;
      if (wrap)        flag_q <= 1'b1;
      else if (test_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign wake_o = wake_q;

  wt_pin_mux u_pin (
    .buz_en_i(mode.buz_en), .wave_i(wave),
    .latch_i (port_latch_i), .out_i(port_out_i),
    .pin_o   (buz_pin_o)
  );
endmodule

// File: rtl/rtc_watch_timer_chk.sv
module rtc_watch_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] mode_i,
  input logic       test_i,
  input logic       flag_o,
  input logic       wake_o
);
  AST_WAKE_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> flag_o); // R5
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !test_i) |=> flag_o); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[2] |=> !wake_o); // R7
  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[4] |=> !wake_o); // R8
endmodule

bind rtc_watch_timer rtc_watch_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
  .test_i(test_i), .flag_o(flag_o), .wake_o(wake_o)
);

// File: tb/rtc_watch_timer_tb.sv
`timescale 1ns/1ps
module rtc_watch_timer_tb;
  logic       clk, rst_n;
  logic       main_tick, sub_tick, test, latch, pout;
  logic [7:0] mode;
  logic       flag, wake, pin;
  int checks = 0, errors = 0;
  bit model_on = 0;

  // mode bits: 0 src_sub, 1 fast, 2 cnt_en, 3 buz_en, 4 clr
  localparam logic [7:0] SRC = 8'h01, FAST = 8'h02, EN = 8'h04, BUZ = 8'h08, CLR = 8'h10;

  rtc_watch_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .main_tick_i(main_tick), .sub_tick_i(sub_tick),
    .mode_i(mode), .test_i(test), .port_latch_i(latch), .port_out_i(pout),
    .flag_o(flag), .wake_o(wake), .buz_pin_o(pin)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference state built from the requirements
  int  m_pre, m_div;
  bit  m_flag, m_wake;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_div <= 0; m_flag <= 0; m_wake <= 0;
    end else begin
      bit en, clr, ptick, ftick, ev;
      en = mode[2]; clr = mode[4];
      ptick = en && !clr && main_tick && (m_pre == 127);
      ftick = en && !clr && (mode[0] ? sub_tick : ptick);
      ev = ftick && (mode[1] ? ((m_div % 128) == 127) : (m_div == 16383));
      if (clr) m_pre <= 0; else if (en && main_tick) m_pre <= (m_pre + 1) % 128;
      if (clr) m_div <= 0; else if (ftick) m_div <= (m_div + 1) % 16384;
      m_wake <= ev;
      if (ev) m_flag <= 1; else if (test) m_flag <= 0;
    end
  end

  function automatic bit exp_pin(input bit o, input bit be, input bit l, input int d);
    bit w = (d >> 3) & 1;
    return o & (be ? (w & ~l) : l);
  endfunction

  always @(negedge clk) if (model_on && rst_n) begin
    chk(flag == m_flag, "R5 R6 model flag", flag, m_flag);
    chk(wake == m_wake, "R5 model wake", wake, m_wake);
    chk(pin == exp_pin(pout, mode[3], latch, m_div), "R10 model pin", pin,
        exp_pin(pout, mode[3], latch, m_div));
  end

  task automatic clear_div(input logic [7:0] keep);
    @(negedge clk); mode = keep | CLR;
    @(negedge clk); mode = keep;
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!wake && n < 40000);
  endtask

  task automatic pulse_test();
    @(negedge clk); test = 1;
    @(negedge clk); test = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed1234));
    rst_n = 0; main_tick = 0; sub_tick = 0; test = 0; latch = 0; pout = 0; mode = 0;
    repeat (3) @(negedge clk);
    chk(flag == 0 && wake == 0 && pin == 0, "R1 reset outputs", {flag, wake, pin}, 0);
    rst_n = 1;
    model_on = 1;

    // R3 normal mode from subclock, R2 sub source
    sub_tick = 1;
    clear_div(SRC | EN);
    measure(n);
    chk(n == 16384, "R3 normal interval", n, 16384);
    @(negedge clk);
    chk(wake == 0, "R5 wake single cycle", wake, 0);
    repeat (20) @(negedge clk);
    chk(flag == 1, "R6 flag sticky", flag, 1);
    pulse_test();
    chk(flag == 0, "R6 test clears flag", flag, 0);

    // R4 fast mode
    clear_div(SRC | EN | FAST);
    measure(n);
    chk(n == 128, "R4 fast interval", n, 128);

    // R11 reserved bits do not matter
    clear_div(8'hE0 | SRC | EN | FAST);
    measure(n);
    chk(n == 128, "R11 reserved bits ignored", n, 128);

    // R2 main source /128, fast
    sub_tick = 0; main_tick = 1;
    clear_div(EN | FAST);
    measure(n);
    chk(n == 16384, "R2 main prescale fast interval", n, 16384);
    main_tick = 0; sub_tick = 1;

    // R7 hold: 60 ticks, pause 500, remaining 68
    clear_div(SRC | EN | FAST);
    repeat (60) @(negedge clk);
    mode = SRC | FAST;
    n = 0;
    repeat (500) begin @(negedge clk); if (wake) n++; end
    chk(n == 0, "R7 no wrap while disabled", n, 0);
    mode = SRC | EN | FAST;
    measure(n);
    chk(n == 68, "R7 resume from held count", n, 68);

    // R8 clear mid interval then full interval
    repeat (50) @(negedge clk);
    mode = SRC | EN | FAST | CLR;
    n = 0;
    repeat (300) begin @(negedge clk); if (wake) n++; end
    chk(n == 0, "R8 no wrap while cleared", n, 0);
    mode = SRC | EN | FAST;
    measure(n);
    chk(n == 128, "R8 full interval after clear", n, 128);

    // R6 test coincides with wrap
    pulse_test();
    clear_div(SRC | EN | FAST);
    repeat (127) @(negedge clk);
    test = 1;
    @(negedge clk); test = 0;
    chk(flag == 1, "R6 set wins over test", flag, 1);
    pulse_test();

    // R9 buzzer wave
    pout = 1; latch = 0;
    clear_div(SRC | EN | BUZ);
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      chk(pin == (((k % 16) >= 8) ? 1 : 0), "R9 buzzer wave", pin, ((k % 16) >= 8));
    end
    // R10 gating; divider sits at 32+12=44 -> wave high
    sub_tick = 0;
    repeat (12) begin sub_tick = 1; @(negedge clk); end
    sub_tick = 0;
    #1 chk(pin == 1, "R10 buzzer passes", pin, 1);
    latch = 1; #1 chk(pin == 0, "R10 latch high blocks buzzer", pin, 0);
    mode = SRC | EN; #1 chk(pin == 1, "R10 buzzer off shows latch", pin, 1);
    pout = 0; #1 chk(pin == 0, "R10 output mode off", pin, 0);
    sub_tick = 1;

    // random phase, compared against the reference every cycle
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      main_tick = $urandom_range(0, 1);
      sub_tick  = ($urandom_range(0, 3) != 0);
      test      = ($urandom_range(0, 31) == 0);
      latch     = $urandom_range(0, 1);
      pout      = $urandom_range(0, 1);
      mode      = {3'($urandom_range(0, 7)), ($urandom_range(0, 63) == 0),
                   1'($urandom_range(0, 1)), ($urandom_range(0, 15) != 0),
                   ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1))};
    end
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule